// File: doc/BRIEF.md
# Link Controller Event and Interrupt Register Block

This block holds the interrupt and command registers of a small Ethernet link controller. The transmit engine and the receive engine report what happened to each frame as single-cycle event pulses. Each pulse sets a sticky bit in a transmit event register or a receive event register. Each event register has its own enable mask. The host reads the latched events over an 8-bit register bus and acknowledges them by writing ones to the bits it has handled.

A command register lets the host start a DMA transfer, arm reception or start a transmission. The hardware drops each of these enables when a completion pulse arrives for that operation. A read-only summary register collects the state of the block in one byte. It shows the masked transmit line, the masked receive line and a DMA-complete condition, each active-low. It also shows the three busy flags. A single active-high `irq` output follows any of the three active-low conditions.

A transmit mode register carries a read-only count of collisions since the last good transmission in its upper nibble. Its lower nibble is ordinary control storage. Any write to the board reset address returns the whole block to its reset state.

Top module: `link_irq_regs`

## Requirements
- R1: After reset, every register reads 0x00 except the summary at address 6, which reads 0x07. The `irq` output is 0.
- R2: A pulse on `tx_evt` sets the same bits of the transmit event register at address 0, and those bits stay set. The bit meanings are: bit 7 good transmit, bit 6 carrier sense, bit 5 own frame heard, bit 4 shorted medium, bit 3 underflow, bit 2 collision, bit 1 sixteenth collision, bit 0 parity error.
- R3: Writing the transmit event register (address 0) or the receive event register (address 2) clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event pulse for a bit arrives in the same cycle as its clear, the bit stays set.
- R4: The receive event register at address 2 latches `rx_evt` pulses on bit 7 (good frame), bit 4 (reset frame), bit 3 (runt), bit 2 (alignment), bit 1 (CRC) and bit 0 (overflow). Bits 6 and 5 ignore their pulses and always read 0.
- R5: The transmit mask at address 1 and the receive mask at address 3 are read/write, using the same bit positions as their event registers. Receive mask bits 6 and 5 read 0. Summary bit 0 is 0 exactly when (transmit events & transmit mask) is nonzero. Summary bit 1 is 0 exactly when (receive events & receive mask) is nonzero.
- R6: A write to the command register at address 5 sets the DMA enable (bit 7), the receive enable (bit 6) and the transmit enable (bit 5) for each data bit that is 1. Bits 4 to 0 are ignored. Pulses on `dma_done`, `rx_done` and `tx_done` clear the matching enable. The summary shows DMA busy at bit 3, transmit busy at bit 4 and receive busy at bit 5. Summary bits 7 and 6 read 0.
- R7: A `dma_done` pulse while DMA is busy drives summary bit 2 low. The same pulse is ignored while DMA is idle. A new write that sets command bit 7 returns summary bit 2 to 1.
- R8: Bits 7:4 of the mode register at address 4 count collision events (`tx_evt` bit 2). The count saturates at 15. A good-transmit event (`tx_evt` bit 7) resets it to 0, and it wins over a collision in the same cycle. Host writes do not change the count. Bits 3:0 are read/write.
- R9: `irq` is 1 exactly when summary bit 0, 1 or 2 is 0.
- R10: A write of any data to address 7 returns all registers to their R1 values on the next clock edge.
- R11: `host_rdata` is loaded from the addressed register on each clock edge where `host_rd` is 1. It holds its value on all other edges. Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, data appears after the edge |
| host_rdata | output | 8 | Registered read data |
| tx_evt | input | 8 | Transmit event pulses, bit layout per R2 |
| rx_evt | input | 8 | Receive event pulses, bit layout per R4 |
| dma_done | input | 1 | DMA completion pulse |
| rx_done | input | 1 | Reception completion pulse |
| tx_done | input | 1 | Transmission completion pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
The embedded assertions watch several rules on every cycle:
- An event pulse always leaves its bit set.
- A clear with no competing event always empties the bit.
- The collision count never leaves 15 without a good transmit, and it drops to zero after one.
- A completion pulse always drops a running enable.

Other behaviour is only visible through the bench's scripted register accesses:
- the bit positions of each register;
- the active-low coding of the summary and how it combines with the masks;
- the DMA-done pulse being ignored while DMA is idle;
- the board reset write;
- the read-data hold.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int CNT_W = 4;

    // Register addresses
    localparam logic [AW-1:0] A_TXEV   = 4'd0;
    localparam logic [AW-1:0] A_TXMSK  = 4'd1;
    localparam logic [AW-1:0] A_RXEV   = 4'd2;
    localparam logic [AW-1:0] A_RXMSK  = 4'd3;
    localparam logic [AW-1:0] A_MODE   = 4'd4;
    localparam logic [AW-1:0] A_CMD    = 4'd5;
    localparam logic [AW-1:0] A_SUM    = 4'd6;
    localparam logic [AW-1:0] A_BRST   = 4'd7;

    // Bits that exist in each event register
    localparam logic [DW-1:0] TX_VALID = 8'hFF;
    localparam logic [DW-1:0] RX_VALID = 8'h9F;

    // Positions inside the transmit event byte used by the counter
    localparam int TX_OK_BIT   = 7;
    localparam int TX_COLL_BIT = 2;

    typedef struct packed {
        logic [1:0] zero;
        logic       rcv_busy;
        logic       xmt_busy;
        logic       dma_busy;
        logic       dma_fin_n;
        logic       rx_pend_n;
        logic       tx_pend_n;
    } summary_t;

    typedef struct packed {
        logic dma;
        logic rcv;
        logic xmt;
    } cmd_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/lirq_event_reg.sv
module lirq_event_reg
    import lirq_pkg::*;
#(
    parameter logic [DW-1:0] VALID = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] mask,
    output logic          pending
);
    logic [DW-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    stat[i] <= 1'b0;
                    mask[i] <= 1'b0;
                end else begin
                    // event has priority over a same-cycle clear
                    stat[i] <= (stat[i] & ~clr_bits[i]) | evt[i];
                    if (mask_we) mask[i] <= wdata[i];
                end
            end
        end else begin : g_dead
            assign stat[i] = 1'b0;
            assign mask[i] = 1'b0;
        end
    end

    assign pending = |(stat & mask);

    a_r2_event_sticks: assert property (@(posedge clk) disable iff (rst)
        (|(evt & VALID)) |=> ((stat & $past(evt & VALID)) == $past(evt & VALID)));

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (|(clr_bits & ~evt & VALID)) |=> ((stat & $past(clr_bits & ~evt & VALID)) == '0));

endmodule

// File: rtl/lirq_coll_cnt.sv
module lirq_coll_cnt
    import lirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             coll,
    input  logic             ok,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (ok)   cnt <= '0;
        else if (coll) cnt <= sat_inc(cnt);
    end

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        ((&cnt) && !ok) |=> (&cnt));

    a_r8_ok_resets: assert property (@(posedge clk) disable iff (rst)
        ok |=> (cnt == '0));

endmodule

// File: rtl/lirq_cmd_ctrl.sv
module lirq_cmd_ctrl
    import lirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_we,
    input  cmd_t start,
    input  logic dma_done,
    input  logic rx_done,
    input  logic tx_done,
    output cmd_t en,
    output logic dma_fin
);
    cmd_t set_v, done_v;

    always_comb begin
        set_v  = start_we ? start : '0;
        done_v = '{dma: dma_done, rcv: rx_done, xmt: tx_done};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= '0;
            dma_fin <= 1'b0;
        end else begin
            // a start written in the same cycle wins over completion
            en <= set_v | (en & ~done_v);
            if (set_v.dma)                 dma_fin <= 1'b0;
            else if (dma_done && en.dma)   dma_fin <= 1'b1;
        end
    end

    a_r6_autoclear: assert property (@(posedge clk) disable iff (rst)
        (en.xmt && tx_done && !set_v.xmt) |=> !en.xmt);

    a_r7_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        (!dma_fin && !en.dma && !set_v.dma) |=> !dma_fin);

endmodule

// File: rtl/link_irq_regs.sv
module link_irq_regs
    import lirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] tx_evt,
    input  logic [DW-1:0] rx_evt,
    input  logic          dma_done,
    input  logic          rx_done,
    input  logic          tx_done,
    output logic          irq
);
    logic          brd_rst, rst_all;
    logic [DW-1:0] tx_stat, tx_mask, rx_stat, rx_mask;
    logic          tx_pend, rx_pend, dma_fin;
    logic [CNT_W-1:0] coll_cnt;
    logic [DW-CNT_W-1:0] mode_lo;
    cmd_t          cmd_en;
    summary_t      summ;
    logic [DW-1:0] rd_mux;

    assign brd_rst = host_wr && (host_addr == A_BRST);
    assign rst_all = rst | brd_rst;

    lirq_event_reg #(.VALID(TX_VALID)) u_tx (
        .clk(clk), .rst(rst_all), .evt(tx_evt),
        .clr_we(host_wr && host_addr == A_TXEV),
        .mask_we(host_wr && host_addr == A_TXMSK),
        .wdata(host_wdata), .stat(tx_stat), .mask(tx_mask), .pending(tx_pend));

    lirq_event_reg #(.VALID(RX_VALID)) u_rx (
        .clk(clk), .rst(rst_all), .evt(rx_evt),
        .clr_we(host_wr && host_addr == A_RXEV),
        .mask_we(host_wr && host_addr == A_RXMSK),
        .wdata(host_wdata), .stat(rx_stat), .mask(rx_mask), .pending(rx_pend));

    lirq_coll_cnt u_coll (
        .clk(clk), .rst(rst_all),
        .coll(tx_evt[TX_COLL_BIT]), .ok(tx_evt[TX_OK_BIT]), .cnt(coll_cnt));

    lirq_cmd_ctrl u_cmd (
        .clk(clk), .rst(rst_all),
        .start_we(host_wr && host_addr == A_CMD),
        .start(cmd_t'(host_wdata[DW-1:DW-3])),
        .dma_done(dma_done), .rx_done(rx_done), .tx_done(tx_done),
        .en(cmd_en), .dma_fin(dma_fin));

    always_ff @(posedge clk) begin
        if (rst_all)                                mode_lo <= '0;
        else if (host_wr && host_addr == A_MODE)    mode_lo <= host_wdata[DW-CNT_W-1:0];
    end

    always_comb begin
        summ           = '0;
        summ.tx_pend_n = ~tx_pend;
        summ.rx_pend_n = ~rx_pend;
        summ.dma_fin_n = ~dma_fin;
        summ.dma_busy  = cmd_en.dma;
        summ.xmt_busy  = cmd_en.xmt;
        summ.rcv_busy  = cmd_en.rcv;
    end

    assign irq = ~(summ.tx_pend_n & summ.rx_pend_n & summ.dma_fin_n);

    always_comb begin
        case (host_addr)
            A_TXEV:  rd_mux = tx_stat;
            A_TXMSK: rd_mux = tx_mask;
            A_RXEV:  rd_mux = rx_stat;
            A_RXMSK: rd_mux = rx_mask;
            A_MODE:  rd_mux = {coll_cnt, mode_lo};
            A_CMD:   rd_mux = {cmd_en, {(DW-3){1'b0}}};
            A_SUM:   rd_mux = summ;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_all)      host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst_all)
        !host_rd |=> $stable(host_rdata));

    a_r10_board_reset: assert property (@(posedge clk) disable iff (rst)
        brd_rst |=> (tx_stat == '0 && rx_stat == '0 && cmd_en == '0 && coll_cnt == '0));

endmodule

// File: tb/test_link_irq_regs.sv
module test_link_irq_regs;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] host_addr;
    logic [7:0] host_wdata, host_rdata, tx_evt, rx_evt;
    logic       host_wr, host_rd, dma_done, rx_done, tx_done, irq;

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    link_irq_regs i_link_irq_regs (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compare registered read data after each read edge
    always @(posedge clk) begin
        if (host_rd && !rst) begin
            #1;
            if (exp_q.size() > 0) chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic txp(input logic [7:0] v);
        @(negedge clk); tx_evt = v;
        @(negedge clk); tx_evt = '0;
    endtask

    task automatic rxp(input logic [7:0] v);
        @(negedge clk); rx_evt = v;
        @(negedge clk); rx_evt = '0;
    endtask

    task automatic pulse_done(input int which);
        @(negedge clk);
        if (which == 0) dma_done = 1'b1;
        if (which == 1) rx_done = 1'b1;
        if (which == 2) tx_done = 1'b1;
        @(negedge clk); dma_done = 1'b0; rx_done = 1'b0; tx_done = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk); chk(tag, {7'd0, irq}, {7'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; host_addr = '0; host_wdata = '0; host_wr = 0; host_rd = 0;
        tx_evt = '0; rx_evt = '0; dma_done = 0; rx_done = 0; tx_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int a = 0; a < 6; a++) rd(a[3:0], 8'h00, "R1 reset reg");
        rd(4'd6, 8'h07, "R1 reset summary");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 sticky transmit events (ok+coll same cycle: count stays 0)
        txp(8'hA5);
        rd(4'd0, 8'hA5, "R2 tx latch");
        txp(8'h10);
        rd(4'd0, 8'hB5, "R2 tx sticky");

        // R3 write-one-to-clear
        wr(4'd0, 8'h81);
        rd(4'd0, 8'h34, "R3 w1c");
        wr(4'd0, 8'h00);
        rd(4'd0, 8'h34, "R3 zero no effect");
        @(negedge clk); host_addr = 4'd0; host_wdata = 8'h04; host_wr = 1; tx_evt = 8'h04;
        @(negedge clk); host_wr = 0; tx_evt = '0;   // collision count now 1
        rd(4'd0, 8'h34, "R3 event wins clear");

        // R5 / R9 transmit mask and summary bit 0
        rd(4'd6, 8'h07, "R5 unmasked no pend");
        wr(4'd1, 8'h04);
        rd(4'd1, 8'h04, "R5 tx mask rw");
        rd(4'd6, 8'h06, "R5 tx pend low");
        chk_irq(1'b1, "R9 irq tx");
        wr(4'd0, 8'hFF);
        rd(4'd6, 8'h07, "R5 tx cleared");
        chk_irq(1'b0, "R9 irq idle");

        // R4 receive layout
        rxp(8'hFF);
        rd(4'd2, 8'h9F, "R4 rx layout");
        wr(4'd3, 8'hFF);
        rd(4'd3, 8'h9F, "R5 rx mask rw");
        rd(4'd6, 8'h05, "R5 rx pend low");
        wr(4'd2, 8'hFF);
        rd(4'd2, 8'h00, "R3 rx w1c");
        rd(4'd6, 8'h07, "R5 rx cleared");

        // R7 DMA done ignored while idle
        pulse_done(0);
        rd(4'd6, 8'h07, "R7 idle dma_done ignored");
        chk_irq(1'b0, "R7 idle irq");

        // R6 command enables and auto-clear
        wr(4'd5, 8'hFF);
        rd(4'd5, 8'hE0, "R6 cmd set");
        rd(4'd6, 8'h3F, "R6 busy flags");
        pulse_done(2);
        rd(4'd5, 8'hC0, "R6 xmt clear");
        rd(4'd6, 8'h2F, "R6 xmt busy off");
        pulse_done(1);
        rd(4'd6, 8'h0F, "R6 rcv busy off");
        pulse_done(0);
        rd(4'd5, 8'h00, "R6 dma clear");
        rd(4'd6, 8'h03, "R7 dma fin low");
        chk_irq(1'b1, "R9 irq dma");
        wr(4'd5, 8'h80);
        rd(4'd6, 8'h0F, "R7 restart clears fin");
        chk_irq(1'b0, "R9 irq after restart");

        // R8 collision counter
        for (int i = 0; i < 20; i++) txp(8'h04);
        rd(4'd4, 8'hF0, "R8 saturate");
        wr(4'd4, 8'h0A);
        rd(4'd4, 8'hFA, "R8 low rw, count ro");
        txp(8'h80);
        rd(4'd4, 8'h0A, "R8 ok resets");
        txp(8'h04);
        rd(4'd4, 8'h1A, "R8 count one");

        // R11 hold without read
        rd(4'd4, 8'h1A, "R11 read");
        txp(8'h04);
        repeat (2) @(negedge clk);
        chk("R11 hold", host_rdata, 8'h1A);
        rd(4'd9, 8'h00, "R11 unused addr");

        // R10 board reset
        wr(4'd1, 8'hFF);
        chk_irq(1'b1, "R10 pre irq");
        wr(4'd7, 8'h5A);
        for (int a = 0; a < 6; a++) rd(a[3:0], 8'h00, "R10 reset reg");
        rd(4'd6, 8'h07, "R10 summary");
        chk_irq(1'b0, "R10 irq");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule